// File: doc/BRIEF.md
# Link Wake and Restart Controller

This block sits on the controller side of a two-codec serial audio/modem link and owns the link's power-down and wake-up handling. While the link is asleep its bit clock may be stopped, so the block runs entirely from an always-on local clock. It watches the two codec data-in lines through synchronizers. A low-to-high level change on either line while the link sleeps is taken as a power management event. The block then drives an active-low wake request to the system and records which line raised it. Software clears the request and the record together with a single write-one-to-clear strobe.

Software restarts the link with a cold reset or a warm reset. A cold reset holds the link reset line low for a programmed number of local-clock cycles. A warm reset holds the frame sync line high for a programmed number of cycles while the reset line stays high. After either reset, outgoing traffic to each codec stays gated off until that codec's ready bit has been seen. The ready bit comes from the decoded status slot.

The sequencer has five states. SLEEP is the reset state: the link is down and wake detection is armed. COLD drives the reset line low. WARM drives sync high. WAIT means the link is up and the primary codec's ready bit has not yet been seen. RUN is normal operation. The transitions are:
- any state to COLD on a cold command;
- SLEEP to WARM on a warm command;
- COLD or WARM to WAIT when the pulse counter expires;
- WAIT to RUN when the primary codec reports ready;
- WAIT or RUN to SLEEP on a sleep command.

Top module: `link_wake_ctrl`

## Requirements
- R1: After reset the outputs are: pme_n=1, wake_src=00, link_rst_n=1, link_sync=0, tx_en=00. The sequencer is in SLEEP.
- R2: In SLEEP, a rise on sdin[i] sets wake_src bit i (bit 0 is the primary line, bit 1 the secondary line) and drives pme_n low. The change is visible after the third clock edge following the pin change and not after the second.
- R3: A rise on a data-in line while the sequencer is not in SLEEP sets no wake_src bit and leaves pme_n high.
- R4: A data-in line that stays high raises no further event. This holds after a clear, and also when SLEEP is entered with the line already high.
- R5: pme_n stays low and wake_src keeps its bits until a wake_clr strobe. The strobe clears both at the next edge. If a new rise is detected in the same cycle as the strobe, the new line's bit is set and pme_n stays low.
- R6: A cold command drives link_rst_n low for exactly max(cold_len,1) cycles, starting at the next edge, with link_sync low throughout. The sequencer then enters WAIT.
- R7: A warm command is accepted only in SLEEP. It drives link_sync high for exactly max(warm_len,1) cycles with link_rst_n high, then the sequencer enters WAIT. In any other state the command is ignored.
- R8: tx_en[i] is 0 in SLEEP, COLD and WARM. In WAIT or RUN it rises one edge after codec_ready[i] is seen high, and it then stays high even if ready drops. WAIT moves to RUN when codec_ready[0] is high.
- R9: A sleep command in WAIT or RUN moves the sequencer to SLEEP and turns tx_en off at the next edge.
- R10: When several commands arrive in the same cycle, cold wins over warm and warm wins over sleep.
- R11: A cold command during a warm reset aborts the warm reset. link_sync goes low and link_rst_n goes low at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on local clock |
| rst_n | input | 1 | Active-low block reset |
| sdin | input | N_CODEC | Codec data-in lines, asynchronous |
| cmd_cold | input | 1 | Start cold reset (strobe) |
| cmd_warm | input | 1 | Start warm reset (strobe) |
| cmd_sleep | input | 1 | Power the link down (strobe) |
| cold_len | input | CNT_W | Cold reset length in cycles |
| warm_len | input | CNT_W | Warm reset sync length in cycles |
| wake_clr | input | 1 | Write-one-to-clear for wake request and source |
| codec_ready | input | N_CODEC | Per-codec ready bit from the status slot |
| pme_n | output | 1 | Active-low wake request to the system |
| wake_src | output | N_CODEC | Lines that raised a wake event |
| link_rst_n | output | 1 | Link reset line, active low |
| link_sync | output | 1 | Link frame sync line |
| tx_en | output | N_CODEC | Per-codec outgoing data enable |

## Verification
A detected rise on one line can fall in the same cycle as the software clear strobe, so setting and clearing the wake record compete. The bench raises the secondary line while the primary bit is already recorded. It times wake_clr to land exactly on the edge where the synchronized rise is taken. It then expects only the secondary bit to remain set, with pme_n still low. Command priority is judged the same way, by issuing two commands in one cycle and checking which reset line moves.

// File: rtl/link_wake_pkg.sv
package link_wake_pkg;

    typedef enum logic [2:0] {
        ST_SLEEP = 3'd0,
        ST_COLD  = 3'd1,
        ST_WARM  = 3'd2,
        ST_WAIT  = 3'd3,
        ST_RUN   = 3'd4
    } link_state_t;

endpackage

// File: rtl/link_wake_sync.sv
module link_wake_sync #(
    parameter int N_CODEC = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_CODEC-1:0] line_in,
    output logic [N_CODEC-1:0] rise
);

    for (genvar i = 0; i < N_CODEC; i++) begin : g_line
        logic meta_q;
        logic stab_q;
        logic prev_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                meta_q <= line_in[i];
                stab_q <= meta_q;
                prev_q <= stab_q;
            end
        end

        assign rise[i] = stab_q & ~prev_q;
    end

endmodule

// File: rtl/link_wake_seq.sv
module link_wake_seq
    import link_wake_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_cold,
    input  logic             cmd_warm,
    input  logic             cmd_sleep,
    input  logic [CNT_W-1:0] cold_len,
    input  logic [CNT_W-1:0] warm_len,
    input  logic             primary_ready,
    output logic             link_rst_n,
    output logic             link_sync,
    output logic             link_up,
    output logic             in_sleep
);

    link_state_t      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] cold_m1, warm_m1;

    assign cold_m1 = (cold_len == '0) ? '0 : cold_len - 1'b1;
    assign warm_m1 = (warm_len == '0) ? '0 : warm_len - 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SLEEP;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (cmd_cold) begin
            state_d = ST_COLD;
            cnt_d   = cold_m1;
        end else begin
            unique case (state_q)
                ST_SLEEP: begin
                    if (cmd_warm) begin
                        state_d = ST_WARM;
                        cnt_d   = warm_m1;
                    end
                end
                ST_COLD, ST_WARM: begin
                    if (cnt_q == '0) state_d = ST_WAIT;
                    else             cnt_d   = cnt_q - 1'b1;
                end
                ST_WAIT: begin
                    if (cmd_sleep)          state_d = ST_SLEEP;
                    else if (primary_ready) state_d = ST_RUN;
                end
                ST_RUN: begin
                    if (cmd_sleep) state_d = ST_SLEEP;
                end
                default: state_d = ST_SLEEP;
            endcase
        end
    end

    always_comb begin
        link_rst_n = 1'b1;
        link_sync  = 1'b0;
        link_up    = 1'b0;
        in_sleep   = 1'b0;
        unique case (state_q)
            ST_SLEEP: in_sleep   = 1'b1;
            ST_COLD:  link_rst_n = 1'b0;
            ST_WARM:  link_sync  = 1'b1;
            ST_WAIT:  link_up    = 1'b1;
            ST_RUN:   link_up    = 1'b1;
            default:  in_sleep   = 1'b1;
        endcase
    end

endmodule

// File: rtl/link_wake_flag.sv
module link_wake_flag #(
    parameter int N_CODEC = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_CODEC-1:0] rise,
    input  logic               armed,
    input  logic               clr,
    output logic [N_CODEC-1:0] src,
    output logic               pme_n
);

    logic [N_CODEC-1:0] set;
    logic               pme_q;

    assign set = rise & {N_CODEC{armed}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src   <= '0;
            pme_q <= 1'b0;
        end else begin
            src   <= (clr ? '0 : src) | set;
            pme_q <= (pme_q & ~clr) | (|set);
        end
    end

    assign pme_n = ~pme_q;

endmodule

// File: rtl/link_wake_gate.sv
module link_wake_gate #(
    parameter int N_CODEC = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               link_up,
    input  logic [N_CODEC-1:0] ready,
    output logic [N_CODEC-1:0] tx_en
);

    for (genvar i = 0; i < N_CODEC; i++) begin : g_codec
        logic seen_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       seen_q <= 1'b0;
            else if (link_up) seen_q <= seen_q | ready[i];
            else              seen_q <= 1'b0;
        end

        assign tx_en[i] = seen_q & link_up;
    end

endmodule

// File: rtl/link_wake_ctrl.sv
module link_wake_ctrl #(
    parameter int N_CODEC = 2,
    parameter int CNT_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_CODEC-1:0] sdin,
    input  logic               cmd_cold,
    input  logic               cmd_warm,
    input  logic               cmd_sleep,
    input  logic [CNT_W-1:0]   cold_len,
    input  logic [CNT_W-1:0]   warm_len,
    input  logic               wake_clr,
    input  logic [N_CODEC-1:0] codec_ready,
    output logic               pme_n,
    output logic [N_CODEC-1:0] wake_src,
    output logic               link_rst_n,
    output logic               link_sync,
    output logic [N_CODEC-1:0] tx_en
);

    logic [N_CODEC-1:0] line_rise;
    logic               link_up;
    logic               in_sleep;

    link_wake_sync #(.N_CODEC(N_CODEC)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (sdin),
        .rise    (line_rise)
    );

    link_wake_seq #(.CNT_W(CNT_W)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_cold      (cmd_cold),
        .cmd_warm      (cmd_warm),
        .cmd_sleep     (cmd_sleep),
        .cold_len      (cold_len),
        .warm_len      (warm_len),
        .primary_ready (codec_ready[0]),
        .link_rst_n    (link_rst_n),
        .link_sync     (link_sync),
        .link_up       (link_up),
        .in_sleep      (in_sleep)
    );

    link_wake_flag #(.N_CODEC(N_CODEC)) u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .rise  (line_rise),
        .armed (in_sleep),
        .clr   (wake_clr),
        .src   (wake_src),
        .pme_n (pme_n)
    );

    link_wake_gate #(.N_CODEC(N_CODEC)) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .link_up (link_up),
        .ready   (codec_ready),
        .tx_en   (tx_en)
    );

endmodule

// File: rtl/link_wake_checker.sv
module link_wake_checker #(
    parameter int N_CODEC = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               pme_n,
    input logic               wake_clr,
    input logic [N_CODEC-1:0] wake_src,
    input logic               link_rst_n,
    input logic               link_sync,
    input logic [N_CODEC-1:0] tx_en,
    input logic [N_CODEC-1:0] codec_ready,
    input logic               in_sleep
);

    assert_reset_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!link_rst_n && link_sync));

    assert_pme_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!pme_n && !wake_clr) |=> !pme_n);

    assert_pme_sleep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pme_n) |-> $past(in_sleep));

    assert_src_sleep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((wake_src & ~$past(wake_src)) != '0) |-> $past(in_sleep));

    assert_tx_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((tx_en & ~$past(tx_en) & ~$past(codec_ready)) == '0));

    assert_tx_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!link_rst_n || link_sync || in_sleep) |-> (tx_en == '0));

endmodule

bind link_wake_ctrl link_wake_checker #(.N_CODEC(N_CODEC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pme_n       (pme_n),
    .wake_clr    (wake_clr),
    .wake_src    (wake_src),
    .link_rst_n  (link_rst_n),
    .link_sync   (link_sync),
    .tx_en       (tx_en),
    .codec_ready (codec_ready),
    .in_sleep    (in_sleep)
);

// File: tb/link_wake_ctrl_bench.sv
`timescale 1ns/1ps
module link_wake_ctrl_bench;

    localparam int N = 2;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [N-1:0] sdin;
    logic         cmd_cold, cmd_warm, cmd_sleep, wake_clr;
    logic [W-1:0] cold_len, warm_len;
    logic [N-1:0] codec_ready;
    logic         pme_n, link_rst_n, link_sync;
    logic [N-1:0] wake_src, tx_en;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    link_wake_ctrl #(.N_CODEC(N), .CNT_W(W)) u_link_wake_ctrl (
        .clk(clk), .rst_n(rst_n), .sdin(sdin), .cmd_cold(cmd_cold),
        .cmd_warm(cmd_warm), .cmd_sleep(cmd_sleep), .cold_len(cold_len),
        .warm_len(warm_len), .wake_clr(wake_clr), .codec_ready(codec_ready),
        .pme_n(pme_n), .wake_src(wake_src), .link_rst_n(link_rst_n),
        .link_sync(link_sync), .tx_en(tx_en)
    );

    task automatic tick(int n = 1);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int eff_len(int len);
        return (len == 0) ? 1 : len;
    endfunction

    task automatic pulse_sleep();
        cmd_sleep = 1'b1; tick(); cmd_sleep = 1'b0;
    endtask

    task automatic pulse_clr();
        wake_clr = 1'b1; tick(); wake_clr = 1'b0;
    endtask

    task automatic measure_cold(int len);
        int n = 0;
        int bad_sync = 0;
        cold_len = W'(len);
        cmd_cold = 1'b1; tick(); cmd_cold = 1'b0;
        while (!link_rst_n && n < 100) begin
            n++;
            if (link_sync) bad_sync++;
            tick();
        end
        chk("R6 cold low cycles", n, eff_len(len));
        chk("R6 sync low during cold", bad_sync, 0);
    endtask

    task automatic measure_warm(int len);
        int n = 0;
        int bad_rst = 0;
        warm_len = W'(len);
        cmd_warm = 1'b1; tick(); cmd_warm = 1'b0;
        while (link_sync && n < 100) begin
            n++;
            if (!link_rst_n) bad_rst++;
            tick();
        end
        chk("R7 warm sync cycles", n, eff_len(len));
        chk("R7 reset high during warm", bad_rst, 0);
        chk("R8 tx off on first WAIT cycle", int'(tx_en), 0);
        tick();
        chk("R8 tx restored after ready", int'(tx_en), int'(codec_ready));
    endtask

    initial begin
        #(100000 * 4);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; sdin = '0; cmd_cold = 0; cmd_warm = 0; cmd_sleep = 0;
        wake_clr = 0; cold_len = '0; warm_len = '0; codec_ready = '0;
        tick(3);
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1 pme_n", int'(pme_n), 1);
        chk("R1 wake_src", int'(wake_src), 0);
        chk("R1 link_rst_n", int'(link_rst_n), 1);
        chk("R1 link_sync", int'(link_sync), 0);
        chk("R1 tx_en", int'(tx_en), 0);

        // R2 wake from primary line, exact latency
        sdin = 2'b01;
        tick(2);
        chk("R2 not yet after two edges", int'(pme_n), 1);
        tick();
        chk("R2 pme_n low", int'(pme_n), 0);
        chk("R2 src primary", int'(wake_src), 1);

        // R5 hold, then clear; R4 no retrigger while held high
        tick(4);
        chk("R5 pme held", int'(pme_n), 0);
        pulse_clr();
        chk("R5 pme cleared", int'(pme_n), 1);
        chk("R5 src cleared", int'(wake_src), 0);
        tick(5);
        chk("R4 held line no retrigger pme", int'(pme_n), 1);
        chk("R4 held line no retrigger src", int'(wake_src), 0);

        // R2 secondary line
        sdin = 2'b00; tick(3);
        sdin = 2'b10; tick(3);
        chk("R2 src secondary", int'(wake_src), 2);
        pulse_clr();

        // R5 set and clear in the same cycle
        sdin = 2'b00; tick(3);
        sdin = 2'b01; tick(3);
        chk("R5 primary recorded", int'(wake_src), 1);
        sdin = 2'b11;
        tick(2);
        wake_clr = 1'b1; tick(); wake_clr = 1'b0;
        chk("R5 new bit survives clear", int'(wake_src), 2);
        chk("R5 pme stays low on collision", int'(pme_n), 0);
        pulse_clr();
        chk("R5 collision cleared", int'(pme_n), 1);

        // R6 cold sweep
        for (int len = 0; len < 6; len++) measure_cold(len);

        // R3 rise outside SLEEP ignored (sequencer in WAIT)
        sdin = 2'b00; tick(3);
        sdin = 2'b01; tick(4);
        chk("R3 pme unaffected outside sleep", int'(pme_n), 1);
        chk("R3 src unaffected outside sleep", int'(wake_src), 0);

        // R8 ready gating
        chk("R8 tx off before ready", int'(tx_en), 0);
        codec_ready = 2'b10; tick();
        chk("R8 secondary enabled", int'(tx_en), 2);
        codec_ready = 2'b11; tick();
        chk("R8 both enabled", int'(tx_en), 3);
        codec_ready = 2'b00; tick(2);
        chk("R8 enable sticky", int'(tx_en), 3);

        // R7 warm ignored in RUN
        cmd_warm = 1'b1; tick(); cmd_warm = 1'b0;
        chk("R7 warm ignored in run", int'(link_sync), 0);
        tick(2);
        chk("R7 still ignored", int'(link_sync), 0);
        chk("R7 tx kept in run", int'(tx_en), 3);

        // R9 sleep; R4 sleep entry with line already high
        pulse_sleep();
        chk("R9 tx off in sleep", int'(tx_en), 0);
        tick(4);
        chk("R4 high line at sleep entry", int'(pme_n), 1);

        // R7 warm sweep
        codec_ready = 2'b11;
        for (int len = 0; len < 6; len++) begin
            measure_warm(len);
            pulse_sleep();
        end

        // R10 cold beats warm
        cmd_cold = 1'b1; cmd_warm = 1'b1; cold_len = 8'd3;
        tick(); cmd_cold = 1'b0; cmd_warm = 1'b0;
        chk("R10 cold wins reset", int'(link_rst_n), 0);
        chk("R10 cold wins sync", int'(link_sync), 0);
        tick(4);
        pulse_sleep();
        // R10 warm beats sleep
        warm_len = 8'd2;
        cmd_warm = 1'b1; cmd_sleep = 1'b1;
        tick(); cmd_warm = 1'b0; cmd_sleep = 1'b0;
        chk("R10 warm wins over sleep", int'(link_sync), 1);
        tick(4);
        pulse_sleep();

        // R11 cold aborts warm
        warm_len = 8'd5;
        cmd_warm = 1'b1; tick(); cmd_warm = 1'b0;
        tick();
        chk("R11 warm running", int'(link_sync), 1);
        cmd_cold = 1'b1; tick(); cmd_cold = 1'b0;
        chk("R11 sync dropped", int'(link_sync), 0);
        chk("R11 reset asserted", int'(link_rst_n), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule